// File: doc/BRIEF.md
# Byte-Strided Peripheral Transfer Sequencer

This block carries a byte, word or long word between a 32-bit data register and an 8-bit peripheral that is wired to only one byte lane of a 16-bit bus. Because the part answers on only every other address, the block spreads the register's bytes across addresses two apart. It issues one single-byte bus cycle per byte. In the read direction it collects the returned bytes back into the register image. The starting address is the lowest byte address of the sequence. It is formed from a base address plus a signed 16-bit displacement.

Address bit 0 never leaves the block as an address line. It picks the strobe instead: the upper strobe for an even address, the lower strobe for an odd one. All bytes of one transfer share the same parity, so they all land on one lane. A one-cycle done pulse closes each transfer. In the read direction a register write-enable accompanies that pulse.

Top module: `stride_xfer`

## Requirements
- R1: Size code 0 gives one bus cycle, code 1 gives two, and code 2 gives four. Code 3 behaves like code 2.
- R2: The first bus cycle uses the address base_i plus disp_i. disp_i is sign-extended to 32 bits before the addition.
- R3: Each later bus cycle uses the previous address plus 2, so every byte of a transfer has the same address parity.
- R4: While a request is out, exactly one strobe is active: bus_uds_o when address bit 0 is 0, bus_lds_o when it is 1. With no request out, neither strobe is active.
- R5: In the write direction (xfer_rd_i=0, bus_we_o=1), the most significant byte of the selected size goes to the lowest address. Each following address takes the next lower byte, and bits 7:0 go last.
- R6: In the read direction (xfer_rd_i=1, bus_we_o=0), the byte from the lowest address becomes the most significant byte of the selected size. A byte read replaces only reg bits 7:0 and a word read only bits 15:0. The remaining bits are taken from reg_i as captured at start.
- R7: done_o is high for exactly one cycle, the cycle after the last byte's acknowledge is sampled. reg_we_o is high in that cycle only for a read.
- R8: A start_i pulse while busy_o is high is ignored. The running transfer keeps its address sequence and byte count.
- R9: After reset the block is idle: busy_o, done_o, bus_req_o, reg_we_o and both strobes are low.
- R10: A pending request holds its address, strobe and write data unchanged until bus_ack_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| xfer_rd_i | input | 1 | 1: peripheral to register, 0: register to peripheral |
| size_i | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| base_i | input | 32 | Base address register value |
| disp_i | input | 16 | Signed displacement |
| reg_i | input | 32 | Data register value at start |
| reg_o | output | 32 | Merged register value, valid with reg_we_o |
| reg_we_o | output | 1 | Register write strobe for reads |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bus_req_o | output | 1 | Byte cycle request |
| bus_we_o | output | 1 | Byte cycle is a write |
| bus_addr_o | output | 31 | Byte address bits 31:1 |
| bus_uds_o | output | 1 | Upper (even) byte strobe |
| bus_lds_o | output | 1 | Lower (odd) byte strobe |
| bus_wdata_o | output | 8 | Write byte |
| bus_rdata_i | input | 8 | Read byte |
| bus_ack_i | input | 1 | Byte cycle acknowledge |

## Verification
A wrong remaining-byte count shows at the ports as early or late done_o, or as a surplus or missing bus cycle. It appears within one acknowledge of the error. A stray address step or a carry into bit 0 shows on the very next request, as a wrong address or a swapped strobe. A misaligned data shifter shows as a wrong byte on bus_wdata_o at the first acknowledge, or as a wrong reg_o in the done cycle. The bench logs every acknowledged byte cycle, so a fault is tied to the byte index where it first appears.

// File: rtl/stride_pkg.sv
package stride_pkg;

  localparam int REG_W  = 32;
  localparam int LANE_W = 8;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } size_e;

  // number of single-byte bus cycles for a size code
  function automatic logic [CNT_W-1:0] lane_count(size_e s);
    case (s)
      SZ_BYTE: lane_count = CNT_W'(1);
      SZ_WORD: lane_count = CNT_W'(2);
      default: lane_count = CNT_W'(4);
    endcase
  endfunction

  // place the most significant byte of the selected size at the top
  function automatic logic [REG_W-1:0] msb_align(logic [REG_W-1:0] v, size_e s);
    case (s)
      SZ_BYTE: msb_align = {v[7:0], 24'h0};
      SZ_WORD: msb_align = {v[15:0], 16'h0};
      default: msb_align = v;
    endcase
  endfunction

  // combine gathered bytes with the untouched upper register bits
  function automatic logic [REG_W-1:0] merge_read(logic [REG_W-1:0] keep,
                                                  logic [REG_W-1:0] gath,
                                                  size_e s);
    case (s)
      SZ_BYTE: merge_read = {keep[31:8], gath[7:0]};
      SZ_WORD: merge_read = {keep[31:16], gath[15:0]};
      default: merge_read = gath;
    endcase
  endfunction

endpackage

// File: rtl/stride_ctrl.sv
module stride_ctrl
  import stride_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic [1:0] size_i,
  input  logic       ack_i,
  output logic       busy_o,
  output logic       load_o,
  output logic       step_o,
  output logic       done_o,
  output logic       rd_q_o,
  output size_e      size_q_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  logic             rd_q;
  size_e            size_q;
  logic             last_w;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q & ack_i;
  assign last_w = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      size_q <= SZ_BYTE;
    end else begin
      done_q <= step_o & last_w;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= lane_count(size_e'(size_i));
        rd_q   <= rd_i;
        size_q <= size_e'(size_i);
      end else if (step_o) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_w) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign rd_q_o   = rd_q;
  assign size_q_o = size_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && last_w) |=> (done_q && !busy_q));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !ack_i) |=> ($stable(cnt_q) && busy_q));

  // R1
  count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0));

endmodule

// File: rtl/stride_addr.sv
module stride_addr #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:1] addr_o,
  output logic              uds_o,
  output logic              lds_o
);

  localparam int EXT_W = ADDR_W - DISP_W;

  function automatic logic [ADDR_W-1:0] first_addr(logic [ADDR_W-1:0] b,
                                                   logic [DISP_W-1:0] d);
    first_addr = b + {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= first_addr(base_i, disp_i);
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_W'(2);
    end
  end

  assign addr_o = addr_q[ADDR_W-1:1];
  assign uds_o  = busy_i & ~addr_q[0];
  assign lds_o  = busy_i &  addr_q[0];

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (addr_q == $past(addr_q) + ADDR_W'(2)));

  // R4
  strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> $onehot({uds_o, lds_o}));

  // R4
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> !(uds_o || lds_o));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !step_i) |=> $stable(addr_q));

endmodule

// File: rtl/stride_lanes.sv
module stride_lanes
  import stride_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [1:0]       size_i,
  input  size_e            size_q_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [7:0]       rdata_i,
  output logic [7:0]       wdata_o,
  output logic [REG_W-1:0] merged_o
);

  logic [REG_W-1:0] wshift_q;
  logic [REG_W-1:0] gath_q;
  logic [REG_W-1:0] keep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wshift_q <= '0;
      gath_q   <= '0;
      keep_q   <= '0;
    end else if (load_i) begin
      wshift_q <= msb_align(reg_i, size_e'(size_i));
      gath_q   <= '0;
      keep_q   <= reg_i;
    end else if (step_i) begin
      wshift_q <= {wshift_q[REG_W-LANE_W-1:0], {LANE_W{1'b0}}};
      gath_q   <= {gath_q[REG_W-LANE_W-1:0], rdata_i};
    end
  end

  assign wdata_o  = wshift_q[REG_W-1 -: LANE_W];
  assign merged_o = merge_read(keep_q, gath_q, size_q_i);

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(wdata_o));

  // R6
  gather_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (gath_q[7:0] == $past(rdata_i)));

endmodule

// File: rtl/stride_xfer.sv
module stride_xfer
  import stride_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              xfer_rd_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [REG_W-1:0]  reg_o,
  output logic              reg_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:1] bus_addr_o,
  output logic              bus_uds_o,
  output logic              bus_lds_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_ack_i
);

  logic  busy_w;
  logic  load_w;
  logic  step_w;
  logic  done_w;
  logic  rd_q_w;
  size_e size_q_w;

  stride_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .rd_i     (xfer_rd_i),
    .size_i   (size_i),
    .ack_i    (bus_ack_i),
    .busy_o   (busy_w),
    .load_o   (load_w),
    .step_o   (step_w),
    .done_o   (done_w),
    .rd_q_o   (rd_q_w),
    .size_q_o (size_q_w)
  );

  stride_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .step_i (step_w),
    .busy_i (busy_w),
    .base_i (base_i),
    .disp_i (disp_i),
    .addr_o (bus_addr_o),
    .uds_o  (bus_uds_o),
    .lds_o  (bus_lds_o)
  );

  stride_lanes u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_w),
    .step_i   (step_w),
    .size_i   (size_i),
    .size_q_i (size_q_w),
    .reg_i    (reg_i),
    .rdata_i  (bus_rdata_i),
    .wdata_o  (bus_wdata_o),
    .merged_o (reg_o)
  );

  assign busy_o    = busy_w;
  assign done_o    = done_w;
  assign bus_req_o = busy_w;
  assign bus_we_o  = busy_w & ~rd_q_w;
  assign reg_we_o  = done_w & rd_q_w;

  // R7
  we_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (done_o && !busy_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(bus_req_o || bus_we_o));

endmodule

// File: tb/stride_xfer_tb.sv
module stride_xfer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        xfer_rd_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] base_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] reg_i = '0;
  logic [31:0] reg_o;
  logic        reg_we_o, busy_o, done_o, bus_req_o, bus_we_o;
  logic [31:1] bus_addr_o;
  logic        bus_uds_o, bus_lds_o;
  logic [7:0]  bus_wdata_o;
  logic [7:0]  bus_rdata_i = '0;
  logic        bus_ack_i = 1'b0;

  always #2 clk = ~clk;

  stride_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .xfer_rd_i(xfer_rd_i),
    .size_i(size_i), .base_i(base_i), .disp_i(disp_i), .reg_i(reg_i),
    .reg_o(reg_o), .reg_we_o(reg_we_o), .busy_o(busy_o), .done_o(done_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_uds_o(bus_uds_o), .bus_lds_o(bus_lds_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int          wait_cycles = 0;
  int          wcnt = 0;
  int          nlog = 0;
  logic [31:0] log_addr [8];
  logic [7:0]  log_wd   [8];
  logic        log_we   [8];
  logic        log_u    [8];
  logic        log_l    [8];

  function automatic logic [7:0] periph_byte(logic [31:0] a);
    return a[8:1] ^ a[16:9] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // peripheral model: acknowledges after wait_cycles idle negedges
  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack_i) begin
        bus_ack_i = 1'b0;
        wcnt = 0;
      end else if (bus_req_o) begin
        if (wcnt >= wait_cycles) begin
          bus_ack_i   = 1'b1;
          bus_rdata_i = periph_byte({bus_addr_o, ~bus_uds_o});
          if (nlog < 8) begin
            log_addr[nlog] = {bus_addr_o, bus_lds_o};
            log_wd[nlog]   = bus_wdata_o;
            log_we[nlog]   = bus_we_o;
            log_u[nlog]    = bus_uds_o;
            log_l[nlog]    = bus_lds_o;
          end
          nlog++;
        end else begin
          wcnt++;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  task automatic t_reset();
    @(negedge clk);
    chk(!busy_o && !done_o && !bus_req_o && !reg_we_o && !bus_uds_o && !bus_lds_o,
        "R9 idle after reset",
        {26'd0, busy_o, done_o, bus_req_o, reg_we_o, bus_uds_o, bus_lds_o}, 32'd0);
  endtask

  // one transfer; ign=1 pulses a second start while busy (R8)
  task automatic t_xfer(input bit rd, input logic [1:0] sz, input logic [31:0] base,
                        input logic [15:0] disp, input logic [31:0] regv,
                        input int w, input bit ign);
    int n;
    logic [31:0] first, a, gath, mask, expv, got_reg;
    bit got_we, seen;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    first = base + {{16{disp[15]}}, disp};
    wait_cycles = w;
    nlog = 0;
    @(negedge clk);
    xfer_rd_i = rd; size_i = sz; base_i = base; disp_i = disp; reg_i = regv;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (ign) begin
      chk(busy_o, "R8 busy before second start", {31'd0, busy_o}, 32'd1);
      start_i = 1'b1; base_i = base + 32'h100; size_i = 2'd0; xfer_rd_i = ~rd;
      @(negedge clk);
      start_i = 1'b0;
    end
    seen = 0; got_reg = '0; got_we = 0;
    for (int c = 0; c < 200 && !seen; c++) begin
      if (done_o) begin
        seen = 1; got_reg = reg_o; got_we = reg_we_o;
      end else begin
        @(negedge clk);
      end
    end
    chk(seen, "R7 done seen", {31'd0, seen}, 32'd1);
    chk(nlog == n, "R1 byte cycle count", nlog, n);
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", {31'd0, done_o}, 32'd0);
    gath = '0;
    for (int k = 0; k < n && k < nlog; k++) begin
      a = first + 32'(2 * k);
      chk(log_addr[k] == a, (k == 0) ? "R2 first address" : "R3 stride address",
          log_addr[k], a);
      chk(log_u[k] == ~a[0] && log_l[k] == a[0], "R4 strobe lane",
          {30'd0, log_u[k], log_l[k]}, {30'd0, ~a[0], a[0]});
      chk(log_we[k] == ~rd, "R5 R6 direction", {31'd0, log_we[k]}, {31'd0, ~rd});
      if (!rd)
        chk(log_wd[k] == 8'(regv >> (8 * (n - 1 - k))), "R5 write byte order",
            {24'd0, log_wd[k]}, {24'd0, 8'(regv >> (8 * (n - 1 - k)))});
      gath = (gath << 8) | {24'd0, periph_byte(a)};
    end
    if (rd) begin
      mask = (n == 1) ? 32'h0000_00FF : (n == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
      expv = (regv & ~mask) | (gath & mask);
      chk(got_reg == expv, "R6 read merge", got_reg, expv);
    end
    chk(got_we == rd, "R7 reg write enable", {31'd0, got_we}, {31'd0, rd});
  endtask

  task automatic t_wait_hold();
    logic [31:1] a0;
    logic [7:0]  d0;
    bit ok;
    wait_cycles = 4;
    nlog = 0;
    @(negedge clk);
    xfer_rd_i = 1'b0; size_i = 2'd1; base_i = 32'h0000_4001; disp_i = 16'h0010;
    reg_i = 32'hDEAD_BE5A; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    a0 = bus_addr_o; d0 = bus_wdata_o; ok = 1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (bus_addr_o != a0 || bus_wdata_o != d0 || !bus_lds_o) ok = 0;
    end
    chk(ok, "R10 hold until ack", {bus_addr_o, 1'b0}, {a0, 1'b0});
    for (int c = 0; c < 50 && busy_o; c++) @(negedge clk);
    chk(!busy_o, "R10 finishes after waits", {31'd0, busy_o}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_xfer(1'b0, 2'd0, 32'h0000_1000, 16'h0004, 32'h1122_3344, 0, 0);
    t_xfer(1'b0, 2'd1, 32'h0000_2001, 16'h0010, 32'hAABB_CCDD, 1, 0);
    t_xfer(1'b0, 2'd2, 32'h0001_0000, 16'hFFFE, 32'h0102_0304, 0, 0);
    t_xfer(1'b0, 2'd3, 32'h0000_3003, 16'h8000, 32'hCAFE_F00D, 2, 0);
    t_xfer(1'b1, 2'd0, 32'h0000_5000, 16'h0022, 32'h9988_7766, 0, 0);
    t_xfer(1'b1, 2'd1, 32'h0000_6001, 16'hFFF0, 32'h1357_9BDF, 1, 0);
    t_xfer(1'b1, 2'd2, 32'h0000_7002, 16'h0100, 32'h0000_0000, 0, 0);
    t_xfer(1'b1, 2'd2, 32'h0000_7FFF, 16'h0000, 32'hFFFF_FFFF, 2, 1);
    t_xfer(1'b0, 2'd2, 32'hFFFF_FFF8, 16'h0002, 32'h8070_6050, 2, 1);
    t_wait_hold();
    summary();
  end

endmodule